// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Fractional Increment

This block keeps a 64-bit time-of-day count in nanoseconds for hardware timestamping. On every cycle of its clock, while enabled, it adds a fixed-point increment with 32 fractional bits. Because of the fraction, the count stays in nanoseconds whatever the clock period is. A 32-bit accumulator holds the fractional part and carries into the integer count. No separate cycle counter is used.

Software reaches the block through a one-cycle strobe bus with 4-bit word addresses. The 64-bit time and the 64-bit increment are each split into two 32-bit words, with rules that keep 64-bit accesses atomic:
- A read of the low time word captures the upper word for a later read.
- A write of the high time word commits the new time.
- A new increment is committed only after both of its words have been written.

A link-speed input reloads the matching default increment whenever the speed changes. At the slowest speed the default increment is zero, so the clock stops.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the time is 0, the enable bit (word 0, bit 0) reads 0, and `bus_rdata` is 0.
- R2: When the enable bit is 0, the time does not change. Writing 1 to bit 0 of word 0 starts the clock. Each cycle in which the registered enable is 1, the clock advances by one increment.
- R3: Each tick adds the 64-bit increment (upper 32 bits whole nanoseconds, lower 32 bits fraction) to the 96-bit pair {time, fraction}. After k ticks from a zero fraction, the time is T + floor(k·inc / 2^32).
- R4: A write to word 1 (time low) only stages the value, and the time is unchanged. A write to word 2 (time high) loads {wdata, staged low} into the time at the next edge. That load overrides any tick in the same cycle.
- R5: Committing a new time clears the fractional accumulator.
- R6: Words 3 (increment low) and 4 (increment high) stage the increment. Writing one half alone leaves the active increment unchanged. Once both halves have been written, in either order, {high, low} becomes active and the staging flags clear. Reads of words 3 and 4 return the active increment.
- R7: `link_speed` encodes 0 = 40G or no link, 1 = 10G, 2 = 1G. The defaults are 0x1_99999999 (1.6 ns), 0x3_33333333 (3.2 ns) and 0x20_00000000 (32 ns). Reset selects the 40G value. A change of `link_speed` loads the new default into the active increment one cycle later, and this takes priority over a bus commit.
- R8: `link_speed` = 3 (100 Mb) loads an increment of 0, so the time stays still even when the clock is enabled.
- R9: A read of word 1 returns the live low half and captures the live high half. A read of word 2 returns that captured value until the next word-1 read. Read data appears on `bus_rdata` the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| link_speed | input | 2 | Current link speed code |
| tod_ns | output | 64 | Live nanosecond time |

## Verification
The bench places a time just below a 32-bit boundary with a 32 ns step, reads the low word, and lets the count cross the boundary before reading the high word. A design that does not capture the high half on the low read returns the already-incremented upper word. Five ticks at the 1.6 ns step land just under 8 ns, so a design that rounds, or keeps the old fraction across a time commit, reports 8 instead of 7. Writes of a single increment half check that neither half commits alone. Link-speed changes, including the zero-increment speed, are checked both through increment readback and through the time advance.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned NS_W   = 64;
    localparam int unsigned FRAC_W = 32;
    localparam int unsigned INC_W  = 2 * REG_W;

    typedef enum logic [1:0] {
        SPD_40G  = 2'd0,
        SPD_10G  = 2'd1,
        SPD_1G   = 2'd2,
        SPD_100M = 2'd3
    } speed_e;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_TIME_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_TIME_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_INC_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_INC_HI  = 4'd4;

    localparam logic [INC_W-1:0] INC_40G = 64'h0000_0001_9999_9999;
    localparam logic [INC_W-1:0] INC_10G = 64'h0000_0003_3333_3333;
    localparam logic [INC_W-1:0] INC_1G  = 64'h0000_0020_0000_0000;
endpackage

// File: rtl/tod_speed_map.sv
module tod_speed_map
    import tod_pkg::*;
(
    input  speed_e             spd_i,
    output logic [INC_W-1:0]   dflt_o
);
    always_comb begin
        case (spd_i)
            SPD_10G:  dflt_o = INC_10G;
            SPD_1G:   dflt_o = INC_1G;
            SPD_100M: dflt_o = '0;
            default:  dflt_o = INC_40G;
        endcase
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int unsigned P_NS_W   = NS_W,
    parameter int unsigned P_FRAC_W = FRAC_W,
    parameter int unsigned P_INC_W  = INC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [P_INC_W-1:0]  inc_i,
    input  logic                load_i,
    input  logic [P_NS_W-1:0]   load_ns_i,
    output logic [P_NS_W-1:0]   ns_o
);
    localparam int unsigned ACC_W = P_NS_W + P_FRAC_W;
    localparam int unsigned WHOLE_W = P_INC_W - P_FRAC_W;

    typedef struct packed {
        logic [P_NS_W-1:0]   ns;
        logic [P_FRAC_W-1:0] frac;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.ns   = load_ns_i;
            cnt_d.frac = '0;
        end else if (en_i) begin
            cnt_d = cnt_t'(ACC_W'(cnt_q) + ACC_W'(inc_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ns_o = cnt_q.ns;

    assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> (ns_o == $past(ns_o)));

    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ns_o == $past(load_ns_i)));

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=>
            ((ns_o - $past(ns_o)) >= P_NS_W'($past(inc_i[P_INC_W-1:P_FRAC_W]))) &&
            ((ns_o - $past(ns_o)) <= P_NS_W'($past(inc_i[P_INC_W-1:P_FRAC_W])) + 1));

    assert_zero_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && (inc_i == '0)) |=> $stable(ns_o));

    if (WHOLE_W < 1) begin : g_bad_width
        initial $error("increment has no integer part");
    end
endmodule

// File: rtl/tod_csr.sv
module tod_csr
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  speed_e             spd_i,
    input  logic [INC_W-1:0]   dflt_i,
    input  logic [NS_W-1:0]    time_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               en_o,
    output logic [INC_W-1:0]   inc_o,
    output logic               load_o,
    output logic [NS_W-1:0]    load_ns_o
);
    typedef struct packed {
        logic              en;
        logic [REG_W-1:0]  tlo;
        logic [REG_W-1:0]  ilo;
        logic [REG_W-1:0]  ihi;
        logic              lo_seen;
        logic              hi_seen;
        logic [INC_W-1:0]  inc;
        logic [REG_W-1:0]  snap;
        logic [REG_W-1:0]  rdata;
        speed_e            spd;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (wr_i) begin
            case (addr_i)
                A_CTRL:    csr_d.en = wdata_i[0];
                A_TIME_LO: csr_d.tlo = wdata_i;
                A_INC_LO: begin
                    csr_d.ilo     = wdata_i;
                    csr_d.lo_seen = 1'b1;
                end
                A_INC_HI: begin
                    csr_d.ihi     = wdata_i;
                    csr_d.hi_seen = 1'b1;
                end
                default: ;
            endcase
        end
        if (csr_d.lo_seen && csr_d.hi_seen) begin
            csr_d.inc     = {csr_d.ihi, csr_d.ilo};
            csr_d.lo_seen = 1'b0;
            csr_d.hi_seen = 1'b0;
        end
        if (spd_i != csr_q.spd) begin
            csr_d.spd     = spd_i;
            csr_d.inc     = dflt_i;
            csr_d.lo_seen = 1'b0;
            csr_d.hi_seen = 1'b0;
        end
        if (rd_i) begin
            case (addr_i)
                A_CTRL:    csr_d.rdata = REG_W'(csr_q.en);
                A_TIME_LO: begin
                    csr_d.rdata = time_i[REG_W-1:0];
                    csr_d.snap  = time_i[NS_W-1:REG_W];
                end
                A_TIME_HI: csr_d.rdata = csr_q.snap;
                A_INC_LO:  csr_d.rdata = csr_q.inc[REG_W-1:0];
                A_INC_HI:  csr_d.rdata = csr_q.inc[INC_W-1:REG_W];
                default:   csr_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q     <= '0;
            csr_q.inc <= INC_40G;
            csr_q.spd <= SPD_40G;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign rdata_o   = csr_q.rdata;
    assign en_o      = csr_q.en;
    assign inc_o     = csr_q.inc;
    assign load_o    = wr_i && (addr_i == A_TIME_HI);
    assign load_ns_o = {wdata_i, csr_q.tlo};

    assert_snap_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == A_TIME_LO) |=>
            (csr_q.snap == $past(time_i[NS_W-1:REG_W])));

    assert_speed_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_i != csr_q.spd) |=> (inc_o == $past(dflt_i)));

    assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_INC_LO && !csr_q.hi_seen && spd_i == csr_q.spd) |=>
            $stable(inc_o));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [1:0]         link_speed,
    output logic [NS_W-1:0]    tod_ns
);
    speed_e            spd;
    logic [INC_W-1:0]  dflt_inc;
    logic [INC_W-1:0]  act_inc;
    logic              run_en;
    logic              t_load;
    logic [NS_W-1:0]   t_load_val;

    assign spd = speed_e'(link_speed);

    tod_speed_map u_map (
        .spd_i  (spd),
        .dflt_o (dflt_inc)
    );

    tod_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .spd_i     (spd),
        .dflt_i    (dflt_inc),
        .time_i    (tod_ns),
        .rdata_o   (bus_rdata),
        .en_o      (run_en),
        .inc_o     (act_inc),
        .load_o    (t_load),
        .load_ns_o (t_load_val)
    );

    tod_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (run_en),
        .inc_i     (act_inc),
        .load_i    (t_load),
        .load_ns_i (t_load_val),
        .ns_o      (tod_ns)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (tod_ns == '0 && bus_rdata == '0));
endmodule

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  link_speed = 2'd0;
    logic [63:0] tod_ns;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    localparam logic [63:0] I40 = 64'h0000_0001_9999_9999;

    always #2.5 clk = ~clk;

    ptp_tod_clock u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .link_speed(link_speed), .tod_ns(tod_ns)
    );

    function automatic logic [63:0] adv(logic [63:0] t, logic [63:0] inc, int k);
        logic [127:0] p;
        p = 128'(inc) * 128'(k);
        return t + p[95:32];
    endfunction

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_pend <= bus_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; bad++;
                $display("FAIL scoreboard: unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk64("R1 time after reset", tod_ns, 64'd0);
        chk64("R1 rdata after reset", {32'd0, bus_rdata}, 64'd0);
        rd(4'd0, 32'd0, "R1 enable reads 0");
        rd(4'd3, 32'h9999_9999, "R7 reset increment low");
        rd(4'd4, 32'h0000_0001, "R7 reset increment high");
        idle(3);
        chk64("R2 disabled clock holds", tod_ns, 64'd0);

        // R4 staged low, commit on high
        wr(4'd1, 32'h1234_5678);
        idle(2);
        chk64("R4 low write alone", tod_ns, 64'd0);
        wr(4'd2, 32'h0000_00AB);
        t = 64'h0000_00AB_1234_5678;
        chk64("R4 high write commits", tod_ns, t);

        // R2/R3 enable and fractional accumulation
        wr(4'd0, 32'd1);
        idle(3);
        chk64("R3 three ticks at 1.6ns", tod_ns, adv(t, I40, 3));
        wr(4'd0, 32'd0);
        chk64("R3 four ticks at 1.6ns", tod_ns, adv(t, I40, 4));
        idle(3);
        chk64("R2 stopped after disable", tod_ns, adv(t, I40, 4));

        // R5 fraction cleared on commit (residue 0.4 would give 8)
        wr(4'd1, 32'd0);
        wr(4'd2, 32'h10);
        wr(4'd0, 32'd1);
        idle(4);
        wr(4'd0, 32'd0);
        chk64("R5 fraction cleared, five ticks", tod_ns, adv(64'h10_0000_0000, I40, 5));

        // R6 increment staging
        wr(4'd3, 32'd0);
        rd(4'd3, 32'h9999_9999, "R6 low half alone keeps increment");
        wr(4'd4, 32'd4);
        rd(4'd4, 32'd4, "R6 both halves commit high");
        rd(4'd3, 32'd0, "R6 both halves commit low");
        wr(4'd4, 32'd7);
        rd(4'd4, 32'd4, "R6 high half alone keeps increment");
        wr(4'd3, 32'h8000_0000);
        rd(4'd4, 32'd7, "R6 reverse order commit high");
        rd(4'd3, 32'h8000_0000, "R6 reverse order commit low");
        wr(4'd1, 32'h100);
        wr(4'd2, 32'd0);
        wr(4'd0, 32'd1);
        idle(1);
        wr(4'd0, 32'd0);
        chk64("R6 advance with 7.5ns", tod_ns, 64'h100 + 64'd15);

        // R7 link speed defaults
        link_speed = 2'd1;
        idle(2);
        rd(4'd4, 32'd3, "R7 10G high");
        rd(4'd3, 32'h3333_3333, "R7 10G low");
        link_speed = 2'd2;
        idle(2);
        rd(4'd4, 32'h20, "R7 1G high");
        rd(4'd3, 32'd0, "R7 1G low");
        wr(4'd1, 32'd0);
        wr(4'd2, 32'd0);
        wr(4'd0, 32'd1);
        idle(1);
        wr(4'd0, 32'd0);
        chk64("R7 two ticks at 32ns", tod_ns, 64'd64);

        // R8 zero increment stops clock
        link_speed = 2'd3;
        idle(2);
        rd(4'd4, 32'd0, "R8 100M increment high");
        rd(4'd3, 32'd0, "R8 100M increment low");
        wr(4'd1, 32'h500);
        wr(4'd2, 32'd0);
        wr(4'd0, 32'd1);
        idle(5);
        chk64("R8 enabled but stopped", tod_ns, 64'h500);
        wr(4'd0, 32'd0);

        // R9 low read captures high half
        link_speed = 2'd2;
        idle(2);
        wr(4'd1, 32'hFFFF_FFF0);
        wr(4'd2, 32'h5);
        wr(4'd0, 32'd1);
        rd(4'd1, 32'hFFFF_FFF0, "R9 low read live value");
        idle(5);
        chk64("R9 live high moved on", {32'd0, tod_ns[63:32]}, 64'd6);
        rd(4'd2, 32'd5, "R9 high read returns captured half");
        wr(4'd0, 32'd0);
        rd(4'd2, 32'd5, "R9 capture persists");
        rd(4'd0, 32'd0, "R2 enable reads back 0");

        idle(4);
        chk64("scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule